// File: doc/BRIEF.md
# Linked-List Command Walker

This block follows a chain of command blocks held in a word-addressed main memory and hands every payload word, in order, to a downstream command consumer. Each block begins with one header word. Its top byte gives the number of payload words that follow it directly in memory. Its low 24 bits give the byte address of the next block. The walker reads a header, streams that many payload words, and then moves to the next block. It stops at an address whose end bit is set.

A host starts a walk with a one-cycle pulse and an initial byte address. The walker then issues single-word reads on a memory port with a fixed one-cycle latency. Payload words leave through a valid/ready stream. When the walk ends, the block gives a one-cycle done pulse, the final pointer value as a progress address, and a cost estimate summed over the blocks it visited. A node limit ends chains that would otherwise never terminate. A flag reports that this limit caused the stop.

Top module: `lw_list_walker`

## Requirements
- R1: A header word carries the payload length in bits 31:24 and the next block's byte address in bits 23:0.
- R2: Bit 23 of the current address is tested before every header fetch. When it is set, the walk ends without any read, so a start address with bit 23 set forwards no words and reports cost 0.
- R3: A byte address is turned into a memory word address from bits 20:2 alone. Bits 22:21 and 1:0 have no effect on which word is read.
- R4: The payload words are the ones stored directly after the header. They leave on `out_data` in ascending address order, up to a length of 255. A length of 0 forwards nothing, and the walk moves straight to the next pointer.
- R5: `cost` is 0 after reset and is cleared by an accepted start. It grows by 5 plus the payload length for every header read, and it holds its value after done until the next start.
- R6: If NODE_LIMIT headers have been read and the current address still has bit 23 clear, the walk stops with `looped` high. `looped` is low for a stop caused by bit 23.
- R7: `done` is high for exactly one cycle per walk. It rises only after the last payload word has been accepted. With it, `progress_addr` shows the last next-pointer value, or the start address for an empty list.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` stays stable. Every payload word is delivered exactly once, whatever the pattern of back-pressure.
- R9: A start pulse that arrives while `busy` is high is ignored. The running walk ends with the same words, cost and progress it would have produced without that pulse.
- R10: After reset the block is idle. `busy`, `done`, `looped`, `out_valid` and `mem_rd` are low, and `cost` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a walk |
| start_addr | input | 24 | Byte address of the first block |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | MEM_AW (19) | Memory word address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| looped | output | 1 | Last walk stopped on the node limit |
| progress_addr | output | 24 | Final pointer value |
| cost | output | COST_W (32) | Accumulated cost estimate |

## Verification
The bench builds the walker with NODE_LIMIT set to 16 and keeps the memory and cost widths at their defaults. With the small limit, a block that points back to itself reaches the loop guard after sixteen visits, so R6 and its progress and cost values can be checked in a few hundred cycles. The bench memory covers only 1024 words. Because of that, the upper address bits that must be ignored, and a full 255-word payload, both fit into one compact image.

// File: rtl/lw_pkg.sv
// lw_pkg: shared constants and state encoding for the list walker.
// Assumes 32-bit header words with a 24-bit pointer field.
package lw_pkg;
    localparam int WORD_W    = 32;
    localparam int PTR_W     = 24;
    localparam int LEN_W     = WORD_W - PTR_W;
    localparam int END_BIT   = 23;
    localparam int NODE_BASE = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR,
        ST_PAY_RD,
        ST_PAY_WAIT
    } lw_state_e;
endpackage

// File: rtl/lw_out_slot.sv
// lw_out_slot: one-entry holding register that drives the payload stream.
// Assumes the producer loads only when `free` was high in the cycle it
// issued the matching memory read.
module lw_out_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              free
);
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    // Slot can take a word next cycle if empty now or drained this edge.
    always_comb free = !valid_q || out_ready;

    // Hold the word until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            data_q  <= load_data;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid = valid_q;
    assign out_data  = data_q;

    // R8
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!valid_q || out_ready));
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !out_ready) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/lw_tally.sv
// lw_tally: accumulates the cost estimate and counts visited nodes.
// Assumes `step` is high once per header read and `clear` on walk start.
module lw_tally #(
    parameter int COST_W     = 32,
    parameter int LEN_W      = 8,
    parameter int NODE_LIMIT = 8192,
    parameter int BASE       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [LEN_W-1:0]  len,
    output logic [COST_W-1:0] cost,
    output logic              at_limit
);
    localparam int CNT_W = $clog2(NODE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NODE_LIMIT);

    logic [CNT_W-1:0]  cnt_q;
    logic [COST_W-1:0] cost_q;

    // Add the per-node cost and count the node on each header.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            cost_q <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
            cost_q <= cost_q + COST_W'(BASE) + COST_W'(len);
        end
    end

    always_comb at_limit = (cnt_q == LIMIT);
    assign cost = cost_q;

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q < LIMIT));
endmodule

// File: rtl/lw_list_walker.sv
// lw_list_walker: walks a chain of length/pointer headers in word memory
// and streams each node's payload to a valid/ready consumer.
// Assumes memory read data arrives exactly one cycle after mem_rd.
module lw_list_walker #(
    parameter int MEM_AW     = 19,
    parameter int NODE_LIMIT = 8192,
    parameter int COST_W     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [lw_pkg::PTR_W-1:0]  start_addr,
    output logic                      mem_rd,
    output logic [MEM_AW-1:0]         mem_addr,
    input  logic [lw_pkg::WORD_W-1:0] mem_rdata,
    output logic                      out_valid,
    output logic [lw_pkg::WORD_W-1:0] out_data,
    input  logic                      out_ready,
    output logic                      busy,
    output logic                      done,
    output logic                      looped,
    output logic [lw_pkg::PTR_W-1:0]  progress_addr,
    output logic [COST_W-1:0]         cost
);
    import lw_pkg::*;

    lw_state_e          state_q;
    logic [PTR_W-1:0]   cur_q;
    logic [MEM_AW-1:0]  rd_ptr_q;
    logic [LEN_W-1:0]   remain_q;
    logic               done_q;
    logic               looped_q;
    logic               slot_free;
    logic               at_limit;
    logic               stop_now;
    logic               hdr_step;
    logic               tally_clr;
    logic               slot_load;
    logic [LEN_W-1:0]   hdr_len;
    logic [MEM_AW-1:0]  cur_word;

    always_comb hdr_len   = mem_rdata[WORD_W-1:PTR_W];
    always_comb cur_word  = cur_q[MEM_AW+1:2];
    always_comb stop_now  = cur_q[END_BIT] || at_limit;
    always_comb hdr_step  = (state_q == ST_HDR);
    always_comb tally_clr = (state_q == ST_IDLE) && start;
    always_comb slot_load = (state_q == ST_PAY_WAIT);

    // Memory request: header at node check, payload when the slot frees.
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        if (state_q == ST_CHECK && !stop_now) begin
            mem_rd   = 1'b1;
            mem_addr = cur_word;
        end else if (state_q == ST_PAY_RD && slot_free) begin
            mem_rd   = 1'b1;
            mem_addr = rd_ptr_q;
        end
    end

    // Walk sequencing: check, header, payload words, next node.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            rd_ptr_q <= '0;
            remain_q <= '0;
            done_q   <= 1'b0;
            looped_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_q    <= start_addr;
                        looped_q <= 1'b0;
                        state_q  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (stop_now) begin
                        if (!out_valid) begin
                            done_q   <= 1'b1;
                            looped_q <= !cur_q[END_BIT];
                            state_q  <= ST_IDLE;
                        end
                    end else begin
                        rd_ptr_q <= cur_word + 1'b1;
                        state_q  <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    cur_q    <= mem_rdata[PTR_W-1:0];
                    remain_q <= hdr_len;
                    state_q  <= (hdr_len == '0) ? ST_CHECK : ST_PAY_RD;
                end
                ST_PAY_RD: begin
                    if (slot_free) state_q <= ST_PAY_WAIT;
                end
                ST_PAY_WAIT: begin
                    rd_ptr_q <= rd_ptr_q + 1'b1;
                    remain_q <= remain_q - 1'b1;
                    state_q  <= (remain_q == LEN_W'(1)) ? ST_CHECK : ST_PAY_RD;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    lw_out_slot #(.DATA_W(WORD_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (slot_load),
        .load_data (mem_rdata),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .free      (slot_free)
    );

    lw_tally #(
        .COST_W     (COST_W),
        .LEN_W      (LEN_W),
        .NODE_LIMIT (NODE_LIMIT),
        .BASE       (NODE_BASE)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tally_clr),
        .step     (hdr_step),
        .len      (hdr_len),
        .cost     (cost),
        .at_limit (at_limit)
    );

    assign busy          = (state_q != ST_IDLE);
    assign done          = done_q;
    assign looped        = looped_q;
    assign progress_addr = cur_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && !busy));
    // R2
    end_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (progress_addr[END_BIT] || looped));
    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && state_q != ST_CHECK) |=> busy);
endmodule

// File: tb/tb_lw_list_walker.sv
module tb_lw_list_walker;
    typedef struct packed {
        logic [23:0] start;
        logic [15:0] nwords;
        logic [31:0] cost;
        logic [23:0] prog;
        logic        loop;
        logic [31:0] first;
        logic        step;
        logic        stall;
    } row_t;

    // Rows: R1/R4 chain, R2 empty, R3 masked bits, R6 loop, R8 stalls, R4 max length
    localparam row_t ROWS [0:5] = '{
        '{24'h000040, 16'd5,   32'd20,  24'h800000, 1'b0, 32'd1,  1'b1, 1'b0},
        '{24'h800123, 16'd0,   32'd0,   24'h800123, 1'b0, 32'd0,  1'b1, 1'b0},
        '{24'h600200, 16'd1,   32'd6,   24'hFFFFFF, 1'b0, 32'd1,  1'b1, 1'b0},
        '{24'h000300, 16'd16,  32'd96,  24'h000300, 1'b1, 32'h77, 1'b0, 1'b0},
        '{24'h000040, 16'd5,   32'd20,  24'h800000, 1'b0, 32'd1,  1'b1, 1'b1},
        '{24'h000400, 16'd255, 32'd260, 24'h800000, 1'b0, 32'd1,  1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic        mem_rd;
    logic [18:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;
    logic        busy, done, looped;
    logic [23:0] progress_addr;
    logic [31:0] cost;

    logic [31:0] mem [0:1023];
    logic [31:0] cap [0:511];
    int          cap_n = 0;
    logic        cap_clr = 1'b0;
    logic        stall = 1'b0;
    logic        force_low = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    int          hold_err = 0;
    logic        prev_hold = 1'b0;
    logic [31:0] prev_data = '0;
    int          checks = 0;
    int          failures = 0;
    logic        got_done;

    always #5 clk = ~clk;

    lw_list_walker #(.NODE_LIMIT(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .busy(busy), .done(done), .looped(looped),
        .progress_addr(progress_addr), .cost(cost)
    );

    // Memory model with one-cycle read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];

    // Consumer ready pattern
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= force_low ? 1'b0 : (stall ? lfsr[0] : 1'b1);
    end

    // Capture accepted words and watch the hold rule
    always @(posedge clk) begin
        if (prev_hold && out_data != prev_data) hold_err <= hold_err + 1;
        prev_hold <= out_valid && !out_ready;
        prev_data <= out_data;
        if (cap_clr) cap_n <= 0;
        else if (out_valid && out_ready) begin
            if (cap_n < 512) cap[cap_n] <= out_data;
            cap_n <= cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [23:0] a);
        @(negedge clk); cap_clr = 1'b1;
        @(negedge clk); cap_clr = 1'b0; start = 1'b1; start_addr = a;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        got_done = 1'b0;
        for (int i = 0; i < limit && !got_done; i++) begin
            @(posedge clk); #1;
            if (done) got_done = 1'b1;
        end
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD0000 | i;
        mem[10'h010] = {8'd3, 24'h000100};
        mem[10'h011] = 1; mem[10'h012] = 2; mem[10'h013] = 3;
        mem[10'h040] = {8'd0, 24'h000080};
        mem[10'h020] = {8'd2, 24'h800000};
        mem[10'h021] = 4; mem[10'h022] = 5;
        mem[10'h080] = {8'd1, 24'hFFFFFF};
        mem[10'h081] = 1;
        mem[10'h0C0] = {8'd1, 24'h000300};
        mem[10'h0C1] = 32'h77;
        mem[10'h100] = {8'd255, 24'h800000};
        for (int i = 1; i < 256; i++) mem[10'h100 + i] = i;

        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(!busy && !done && !looped && !out_valid && !mem_rd, "R10 idle outputs",
            {27'd0, busy, done, looped, out_valid, mem_rd}, 0);
        chk(cost == 0, "R10 cost", cost, 0);
        @(negedge clk); rst_n = 1'b1;

        for (int r = 0; r < 6; r++) begin
            int bad;
            stall = ROWS[r].stall;
            launch(ROWS[r].start);
            wait_done(5000);
            chk(got_done, "R7 done seen", {31'd0, got_done}, 1);
            chk(cost == ROWS[r].cost, "R5 cost", cost, ROWS[r].cost);
            chk(progress_addr == ROWS[r].prog, "R7 progress", {8'd0, progress_addr},
                {8'd0, ROWS[r].prog});
            chk(looped == ROWS[r].loop, "R6 looped flag", {31'd0, looped},
                {31'd0, ROWS[r].loop});
            chk(cap_n == int'(ROWS[r].nwords), "R4 word count", cap_n, ROWS[r].nwords);
            bad = 0;
            for (int k = 0; k < cap_n && k < 512; k++)
                if (cap[k] != ROWS[r].first + (ROWS[r].step ? k : 0)) bad++;
            // R1 R2 R3 R4 payload content and order
            chk(bad == 0, "R1 R3 R4 payload order", bad, 0);
            @(posedge clk); #1;
            chk(!done, "R7 single-cycle done", {31'd0, done}, 0);
        end
        chk(hold_err == 0, "R8 data held under stall", hold_err, 0);

        // R9: second start during a walk is ignored
        stall = 1'b0;
        launch(24'h000040);
        @(negedge clk); start = 1'b1; start_addr = 24'h000400;
        @(negedge clk); start = 1'b0;
        wait_done(5000);
        chk(got_done && cap_n == 5, "R9 word count", cap_n, 5);
        chk(cost == 20, "R9 cost", cost, 20);
        chk(progress_addr == 24'h800000, "R9 progress", {8'd0, progress_addr}, 32'h800000);

        // R7: done waits for the consumer to drain the last word
        force_low = 1'b1;
        launch(24'h600200);
        wait_done(40);
        chk(!got_done && busy && out_valid, "R7 done held while undrained",
            {29'd0, got_done, busy, out_valid}, 3);
        force_low = 1'b0;
        wait_done(100);
        chk(got_done && cap_n == 1 && cap[0] == 1, "R7 done after drain", cap_n, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule